// File: doc/BRIEF.md
# Test-Gated Flag and Control Register File

This block is the control register file of a real-time clock peripheral. It has three registers. The periodic flag register holds six event flags that clear when read, the test enable and a bit that does two jobs. The main status register holds four event flags that clear when a 1 is written to them, plus two plain storage bits. The third location is a byte that works as ordinary RAM. While test mode is on, that byte becomes a test control register. It drives eight decoded control lines into the counter and prescaler datapaths, which lie outside this block.

One bit in the periodic flag register reads and writes different things. A read returns the oscillator-failure flag. A write selects the supply mode. When the oscillator fails, the supply mode is forced to single-supply, unless the test register's failure-disable control is active. Software reaches the block through a plain address and data bus. A read returns data combinationally in the cycle the read strobe is high. Side effects of a read or write take place at the next rising edge. Event inputs are sampled at every rising edge.

Top module: `rtc_flagctl_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, the supply-mode output is 0 (battery-backed) and all test controls and the test-active output are 0.
- R2: Bit 7 of the periodic flag register (address 0x03) is the test enable. It is read/write and appears on `test_active`. While it is 0, all eight test control outputs are 0.
- R3: Address 0x1F reads and writes a RAM byte while test mode is off, and the test control register while it is on. Each keeps its contents while the other is selected, and a write with test mode off leaves the test controls unchanged.
- R4: The test control register bit positions are: bit 0 direct clock, bit 1 counter test, bit 2 MSB clock enable, bit 3 timer0 signal route, bit 4 timer1 signal route, bit 5 timer0 crystal route, bit 6 timer1 crystal route, bit 7 oscillator-fail disable.
- R5: Periodic flag register bits 0..5 are set by `evt_periodic` bits 0..5. They read as 1 from the cycle after the event and clear at the edge that ends a read of that address.
- R6: If a read of the periodic flag register and a set event for a flag fall in the same cycle, that flag stays set.
- R7: Main status register (address 0x00) bits 2..5 are set by `evt_status` bits 0..3. Writing 1 to a bit clears it and writing 0 has no effect. A set event in the same cycle as a clear wins.
- R8: Main status register bits 6 and 7 are plain read/write storage. Bits 0 and 1 read 0.
- R9: Reading periodic flag register bit 6 returns the oscillator-failure flag, which is `osc_fail_det` registered for one cycle. Writing bit 6 sets `single_supply` (1 is single-supply, 0 is battery-backed).
- R10: While `osc_fail_det` is high and the oscillator-fail disable control is not active, `single_supply` is forced to 1 at the next edge, even over a same-cycle write of 0. With the disable control active, the failure flag stays 0 and the supply mode is not forced.
- R11: Writes to periodic flag register bits 0..5 have no effect. Unmapped addresses ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| evt_periodic | input | 6 | Set pulses for the periodic event flags |
| evt_status | input | 4 | Set pulses for the status event flags |
| osc_fail_det | input | 1 | Oscillator failure detector output |
| test_active | output | 1 | Test enable state |
| dir_clk | output | 1 | Direct clock control |
| cnt_test | output | 1 | Counter test control |
| msb_clk_en | output | 1 | MSB clock enable control |
| t0_sig_route | output | 1 | Timer0 signal route control |
| t1_sig_route | output | 1 | Timer1 signal route control |
| t0_xtal_route | output | 1 | Timer0 crystal route control |
| t1_xtal_route | output | 1 | Timer1 crystal route control |
| oscfail_dis | output | 1 | Oscillator-fail disable control |
| single_supply | output | 1 | Supply mode select |

## Verification
A one-hot walk through the test register, with test mode on, separates each control bit's position. Alternating RAM and test-register writes across test-enable toggles show that the aliased byte keeps two separate contents. Event patterns with several bits set, followed by repeated reads, show clear-on-read apart from stickiness. Collisions of a set event with a read or a write-one clear show which side wins. For the supply bit, writes with the detector quiet, high and masked separate the write path, the forced preset and the disable.

// File: rtl/rtc_flagctl_pkg.sv
// Shared widths and the test control layout for the flag/control register file.
// Assumes an 8-bit data bus.
package rtc_flagctl_pkg;
    localparam int DATA_W     = 8;
    localparam int PER_FLAGS  = 6;   // clear-on-read flags at the low end of the periodic register
    localparam int STAT_FLAGS = 4;   // write-one-clear flags in the status register
    localparam int STAT_LSB   = 2;   // first status flag bit position
    localparam int STAT_RW_LSB = STAT_LSB + STAT_FLAGS;           // plain storage bits
    localparam int STAT_RW_W   = DATA_W - STAT_RW_LSB;
    localparam int PER_TEN_BIT  = DATA_W - 1;                     // test enable
    localparam int PER_DUAL_BIT = DATA_W - 2;                     // osc flag read / supply write

    // Test control register, bit 7 down to bit 0.
    typedef struct packed {
        logic osc_fail_dis;
        logic t1_xtal;
        logic t0_xtal;
        logic t1_sig;
        logic t0_sig;
        logic msb_clk;
        logic cnt_test;
        logic dir_clk;
    } tst_ctrl_t;
endpackage

// File: rtl/ev_flag_bank.sv
// A bank of N sticky event flags. A set pulse wins over a clear request in the
// same cycle. The parent builds the clear requests (from a read or a write-one).
// Assumes set and clear are synchronous to clk.
module ev_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic flag_r;
        // One flag: set dominates clear, holds otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_r <= 1'b0;
            else if (set_i[b])
                flag_r <= 1'b1;
            else if (clr_i[b])
                flag_r <= 1'b0;
        end
        assign q_o[b] = flag_r;
    end
endmodule

// File: rtl/test_ram_alias.sv
// One address that holds two bytes: a RAM byte used while test mode is off and
// the test control register used while it is on. Controls leave the block
// only while test mode is on. Assumes writes are one-cycle strobes.
module test_ram_alias
    import rtc_flagctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output tst_ctrl_t         ctrl_o
);
    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] tst_q;

    // RAM byte: written only while test mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ram_q <= '0;
        else if (wr_i && !test_en)
            ram_q <= wdata_i;
    end

    // Test register: written only while test mode is on; resets inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tst_q <= '0;
        else if (wr_i && test_en)
            tst_q <= wdata_i;
    end

    // Read selection and gated control outputs.
    always_comb begin
        rdata_o = test_en ? tst_q : ram_q;
        ctrl_o  = test_en ? tst_ctrl_t'(tst_q) : '0;
    end
endmodule

// File: rtl/supply_mon.sv
// Oscillator-failure flag and supply-mode bit. A live failure (not disabled)
// is registered as the flag and presets single-supply mode, overriding a
// software write in the same cycle. Assumes osc_fail_det is synchronous.
module supply_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_fail_det,
    input  logic dis_i,
    input  logic mode_wr_i,
    input  logic mode_val_i,
    output logic osc_flag_o,
    output logic single_supply_o
);
    logic fail_live;

    // Failure that counts: detector high and not disabled.
    always_comb fail_live = osc_fail_det & ~dis_i;

    // Failure flag follows the qualified detector one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            osc_flag_o <= 1'b0;
        else
            osc_flag_o <= fail_live;
    end

    // Supply mode: failure preset first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            single_supply_o <= 1'b0;
        else if (fail_live)
            single_supply_o <= 1'b1;
        else if (mode_wr_i)
            single_supply_o <= mode_val_i;
    end
endmodule

// File: rtl/rtc_flagctl_regs.sv
// Top of the flag/control register file. Decodes the bus, owns the test
// enable and status storage bits, and muxes read data. Read data is
// combinational; read and write side effects land at the next edge.
// Assumes rd and wr strobes are one cycle per access.
module rtc_flagctl_regs
    import rtc_flagctl_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MSR_ADDR  = 0,
    parameter int PFR_ADDR  = 3,
    parameter int TEST_ADDR = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PER_FLAGS-1:0]  evt_periodic,
    input  logic [STAT_FLAGS-1:0] evt_status,
    input  logic              osc_fail_det,
    output logic              test_active,
    output logic              dir_clk,
    output logic              cnt_test,
    output logic              msb_clk_en,
    output logic              t0_sig_route,
    output logic              t1_sig_route,
    output logic              t0_xtal_route,
    output logic              t1_xtal_route,
    output logic              oscfail_dis,
    output logic              single_supply
);
    localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(MSR_ADDR);
    localparam logic [ADDR_W-1:0] A_PFR = ADDR_W'(PFR_ADDR);
    localparam logic [ADDR_W-1:0] A_TST = ADDR_W'(TEST_ADDR);

    logic hit_msr, hit_pfr, hit_tst;
    logic pfr_rd, pfr_wr, msr_wr, tst_wr;
    logic test_en;
    logic [STAT_RW_W-1:0]  msr_rw;
    logic [PER_FLAGS-1:0]  per_q;
    logic [STAT_FLAGS-1:0] stat_q;
    logic [STAT_FLAGS-1:0] stat_clr;
    logic [DATA_W-1:0]     tst_rd;
    tst_ctrl_t             ctrl;
    logic                  osc_flag;

    // Address decode and access strobes.
    always_comb begin
        hit_msr = (bus_addr == A_MSR);
        hit_pfr = (bus_addr == A_PFR);
        hit_tst = (bus_addr == A_TST);
        pfr_rd  = bus_rd & hit_pfr;
        pfr_wr  = bus_wr & hit_pfr;
        msr_wr  = bus_wr & hit_msr;
        tst_wr  = bus_wr & hit_tst;
        stat_clr = msr_wr ? bus_wdata[STAT_LSB +: STAT_FLAGS] : '0;
    end

    // Test enable bit of the periodic register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            test_en <= 1'b0;
        else if (pfr_wr)
            test_en <= bus_wdata[PER_TEN_BIT];
    end

    // Plain storage bits of the status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msr_rw <= '0;
        else if (msr_wr)
            msr_rw <= bus_wdata[STAT_RW_LSB +: STAT_RW_W];
    end

    ev_flag_bank #(.N(PER_FLAGS)) u_per_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_periodic),
        .clr_i ({PER_FLAGS{pfr_rd}}),
        .q_o   (per_q)
    );

    ev_flag_bank #(.N(STAT_FLAGS)) u_stat_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_status),
        .clr_i (stat_clr),
        .q_o   (stat_q)
    );

    test_ram_alias u_alias (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .wr_i    (tst_wr),
        .wdata_i (bus_wdata),
        .rdata_o (tst_rd),
        .ctrl_o  (ctrl)
    );

    supply_mon u_supply (
        .clk             (clk),
        .rst_n           (rst_n),
        .osc_fail_det    (osc_fail_det),
        .dis_i           (ctrl.osc_fail_dis),
        .mode_wr_i       (pfr_wr),
        .mode_val_i      (bus_wdata[PER_DUAL_BIT]),
        .osc_flag_o      (osc_flag),
        .single_supply_o (single_supply)
    );

    // Read data mux; zero when idle or unmapped.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_msr)
                bus_rdata = {msr_rw, stat_q, {STAT_LSB{1'b0}}};
            else if (hit_pfr)
                bus_rdata = {test_en, osc_flag, per_q};
            else if (hit_tst)
                bus_rdata = tst_rd;
        end
    end

    // Decoded control outputs.
    always_comb begin
        test_active   = test_en;
        dir_clk       = ctrl.dir_clk;
        cnt_test      = ctrl.cnt_test;
        msb_clk_en    = ctrl.msb_clk;
        t0_sig_route  = ctrl.t0_sig;
        t1_sig_route  = ctrl.t1_sig;
        t0_xtal_route = ctrl.t0_xtal;
        t1_xtal_route = ctrl.t1_xtal;
        oscfail_dis   = ctrl.osc_fail_dis;
    end
endmodule

// File: rtl/rtc_flagctl_chk.sv
// Property checker for rtc_flagctl_regs, attached by bind below.
// Assumes the same address parameters as the design instance.
module rtc_flagctl_chk
    import rtc_flagctl_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MSR_ADDR  = 0,
    parameter int PFR_ADDR  = 3,
    parameter int TEST_ADDR = 31
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [PER_FLAGS-1:0]  evt_periodic,
    input logic [STAT_FLAGS-1:0] evt_status,
    input logic                  osc_fail_det,
    input logic                  test_active,
    input logic [DATA_W-1:0]     ctrl_vec,
    input logic                  oscfail_dis,
    input logic                  single_supply,
    input logic [PER_FLAGS-1:0]  per_q,
    input logic [STAT_FLAGS-1:0] stat_q
);
    localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(MSR_ADDR);
    localparam logic [ADDR_W-1:0] A_PFR = ADDR_W'(PFR_ADDR);
    localparam logic [ADDR_W-1:0] A_TST = ADDR_W'(TEST_ADDR);

    // A read with no events leaves every periodic flag clear.
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PFR && evt_periodic == '0) |=> (per_q == '0));

    // Any set event leaves its flag set, read or not.
    assert_set_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_periodic != '0) |=> ((per_q & $past(evt_periodic)) == $past(evt_periodic)));

    // Writing ones clears those status flags when no event arrives.
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MSR && evt_status == '0)
        |=> ((stat_q & $past(bus_wdata[STAT_LSB +: STAT_FLAGS])) == '0));

    // A RAM write with test mode off does not move the controls.
    assert_ram_write_keeps_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TST && !test_active) |=> $stable(ctrl_vec));

    // Supply-mode write takes effect when no failure is present.
    assert_supply_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PFR && !osc_fail_det)
        |=> (single_supply == $past(bus_wdata[PER_DUAL_BIT])));

    // An unmasked failure forces single-supply mode.
    assert_fail_preset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_fail_det && !oscfail_dis) |=> single_supply);
endmodule

bind rtc_flagctl_regs rtc_flagctl_chk #(
    .ADDR_W    (ADDR_W),
    .MSR_ADDR  (MSR_ADDR),
    .PFR_ADDR  (PFR_ADDR),
    .TEST_ADDR (TEST_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .evt_periodic (evt_periodic),
    .evt_status   (evt_status),
    .osc_fail_det (osc_fail_det),
    .test_active  (test_active),
    .ctrl_vec     (ctrl),
    .oscfail_dis  (oscfail_dis),
    .single_supply(single_supply),
    .per_q        (per_q),
    .stat_q       (stat_q)
);

// File: tb/rtc_flagctl_regs_test.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares
// them 3 ns after each falling edge.
module rtc_flagctl_regs_test;
    localparam logic [4:0] A_MSR = 5'h00;
    localparam logic [4:0] A_PFR = 5'h03;
    localparam logic [4:0] A_TST = 5'h1F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] evt_periodic = '0;
    logic [3:0] evt_status = '0;
    logic       osc_fail_det = 1'b0;
    logic test_active, dir_clk, cnt_test, msb_clk_en, t0_sig_route, t1_sig_route;
    logic t0_xtal_route, t1_xtal_route, oscfail_dis, single_supply;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit         is_out;
        logic [9:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    rtc_flagctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_periodic(evt_periodic), .evt_status(evt_status),
        .osc_fail_det(osc_fail_det), .test_active(test_active),
        .dir_clk(dir_clk), .cnt_test(cnt_test), .msb_clk_en(msb_clk_en),
        .t0_sig_route(t0_sig_route), .t1_sig_route(t1_sig_route),
        .t0_xtal_route(t0_xtal_route), .t1_xtal_route(t1_xtal_route),
        .oscfail_dis(oscfail_dis), .single_supply(single_supply)
    );

    // obs = {test_active, single_supply, control byte in test register order}
    function automatic logic [9:0] obs();
        return {test_active, single_supply, oscfail_dis, t1_xtal_route, t0_xtal_route,
                t1_sig_route, t0_sig_route, msb_clk_en, cnt_test, dir_clk};
    endfunction

    task automatic push(bit is_out, logic [9:0] exp, string tag);
        item_t it;
        it.is_out = is_out; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        push(1'b0, {2'b00, exp}, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_out(logic [9:0] exp, string tag);
        @(negedge clk);
        push(1'b1, exp, tag);
    endtask

    // Monitor: compare queued expectations away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sbq.size() > 0) begin
                item_t it;
                logic [9:0] act;
                it = sbq.pop_front();
                act = it.is_out ? obs() : {2'b00, bus_rdata};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_out(10'h000, "R1 outputs after reset");
        rd(A_MSR, 8'h00, "R1 status reg after reset");
        rd(A_PFR, 8'h00, "R1 periodic reg after reset");
        rd(A_TST, 8'h00, "R1 alias byte after reset");

        // R3 RAM with test mode off
        wr(A_TST, 8'hA5);
        rd(A_TST, 8'hA5, "R3 RAM byte readback");
        chk_out(10'h000, "R3 RAM write leaves controls");

        // R2 enable test mode
        wr(A_PFR, 8'h80);
        rd(A_PFR, 8'h80, "R2 test enable readback");
        chk_out(10'h200, "R2 test active");
        rd(A_TST, 8'h00, "R3 test register separate from RAM");

        // R4 one-hot walk
        for (int i = 0; i < 8; i++) begin
            wr(A_TST, 8'(1 << i));
            chk_out(10'h200 | 10'(1 << i), "R4 control bit position");
            rd(A_TST, 8'(1 << i), "R4 test register readback");
        end

        // R2/R3 alias retention across toggles
        wr(A_TST, 8'h5A);
        wr(A_PFR, 8'h00);
        chk_out(10'h000, "R2 controls gated off");
        rd(A_TST, 8'hA5, "R3 RAM kept while test on");
        wr(A_TST, 8'h3C);
        chk_out(10'h000, "R3 RAM write with test off");
        wr(A_PFR, 8'h80);
        rd(A_TST, 8'h5A, "R3 test register kept");
        chk_out(10'h25A, "R3 controls restored");
        wr(A_PFR, 8'h00);
        rd(A_TST, 8'h3C, "R3 RAM write landed");

        // R5 clear on read
        @(negedge clk); evt_periodic = 6'b100101;
        @(negedge clk); evt_periodic = '0;
        rd(A_PFR, 8'h25, "R5 flags set");
        rd(A_PFR, 8'h00, "R5 flags cleared by read");

        // R6 set during read
        @(negedge clk); evt_periodic = 6'h02;
        @(negedge clk); evt_periodic = '0;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_PFR; evt_periodic = 6'h10;
        push(1'b0, 10'h002, "R6 read during event");
        @(negedge clk);
        bus_rd = 1'b0; evt_periodic = '0;
        rd(A_PFR, 8'h10, "R6 colliding flag kept");

        // R11 ignored writes
        wr(A_PFR, 8'h3F);
        rd(A_PFR, 8'h00, "R11 flag bits not writable");
        wr(5'h05, 8'hFF);
        rd(5'h05, 8'h00, "R11 unmapped address");
        chk_out(10'h000, "R11 unmapped write no effect");

        // R7 write-one-clear
        @(negedge clk); evt_status = 4'b1011;
        @(negedge clk); evt_status = '0;
        rd(A_MSR, 8'h2C, "R7 status flags set");
        wr(A_MSR, 8'h00);
        rd(A_MSR, 8'h2C, "R7 write zero no effect");
        wr(A_MSR, 8'h08);
        rd(A_MSR, 8'h24, "R7 write one clears");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_MSR; bus_wdata = 8'h04; evt_status = 4'b0001;
        @(negedge clk);
        bus_wr = 1'b0; evt_status = '0;
        rd(A_MSR, 8'h24, "R7 set wins over clear");
        wr(A_MSR, 8'h24);
        rd(A_MSR, 8'h00, "R7 all cleared");

        // R8 storage bits
        wr(A_MSR, 8'hC3);
        rd(A_MSR, 8'hC0, "R8 storage bits and zero low bits");
        wr(A_MSR, 8'h40);
        rd(A_MSR, 8'h40, "R8 storage rewrite");

        // R9 dual function bit
        wr(A_PFR, 8'h40);
        chk_out(10'h100, "R9 write selects single supply");
        rd(A_PFR, 8'h00, "R9 read shows fail flag not mode");
        wr(A_PFR, 8'h00);
        chk_out(10'h000, "R9 write selects battery");
        @(negedge clk); osc_fail_det = 1'b1;
        @(negedge clk); osc_fail_det = 1'b0;
        bus_rd = 1'b1; bus_addr = A_PFR;
        push(1'b0, 10'h040, "R9 fail flag readable");
        @(negedge clk); bus_rd = 1'b0;
        chk_out(10'h100, "R10 failure presets single supply");

        // R10 preset over same-cycle write
        wr(A_PFR, 8'h00);
        chk_out(10'h000, "R9 back to battery");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_PFR; bus_wdata = 8'h00; osc_fail_det = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; osc_fail_det = 1'b0;
        chk_out(10'h100, "R10 preset beats write");

        // R10 disabled
        wr(A_PFR, 8'h80);
        wr(A_TST, 8'h80);
        @(negedge clk); osc_fail_det = 1'b1;
        @(negedge clk); osc_fail_det = 1'b0;
        bus_rd = 1'b1; bus_addr = A_PFR;
        push(1'b0, 10'h080, "R10 masked fail flag");
        @(negedge clk); bus_rd = 1'b0;
        chk_out(10'h280, "R10 masked failure no preset");
        wr(A_TST, 8'h00);
        wr(A_PFR, 8'h00);
        chk_out(10'h000, "R2 cleanup");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule